// File: doc/BRIEF.md
# Loop-Exit Branch Direction Predictor

This block predicts conditional branches that behave like loop back-edges: they resolve the same way a fixed number of times in a row and then resolve the other way exactly once. A small direct-mapped table keeps, for each tracked branch, the following state:

- the usual direction;
- a running count of usual-direction outcomes since the last exit;
- the learned trip limit;
- a two-bit confidence counter.

The block predicts the opposite direction on the occurrence whose count equals the learned limit. A plain saturating-counter predictor always gets that exit occurrence wrong.

The block has two ports. The lookup port is combinational: a branch address goes in, and hit, confident and direction come out in the same cycle. The resolve port takes a branch address and its actual outcome, and updates the table at the next rising clock edge. The block is meant to sit beside a general direction predictor, and the confident output tells the surrounding logic when to take this block's direction over the other one. Entries are allocated when a resolved branch misses. An active-low asynchronous reset clears every entry.

Top module: `loop_pred`

## Requirements
- R1: While reset is low and after it is released, every entry is invalid, so every lookup reports hit=0 and confident=0.
- R2: A resolve that misses allocates the entry and sets these fields:
  - the usual direction to the resolved outcome;
  - the count to 1;
  - the entry to not-learned;
  - the confidence to 0.

  A lookup of that address then hits, with direction equal to that outcome and confident=0.
- R3: The entry index is ip[3:0]. The tag is an XOR fold of ip[31:4]: tag bit k is the XOR of ip[4+k+8m] over all m. A lookup hits only if the entry is valid and its stored tag equals the address's tag. A missing resolve replaces whatever entry occupies that index.
- R4: While an entry is not learned, it predicts its usual direction. Each usual outcome increments the count. The first opposite outcome stores the current count as the limit, marks the entry learned, clears the count and clears the confidence.
- R5: A learned entry predicts the opposite of its usual direction when count equals limit, and predicts its usual direction otherwise. Direction 1 means taken.
- R6: An exit (opposite outcome) on a learned entry with count equal to limit raises confidence by one, saturating at 3. The confident output is 1 only for a hit on a learned entry whose confidence is 3.
- R7: An exit on a learned entry with count different from limit stores the count as the new limit and clears the confidence. Every exit clears the count.
- R8: A usual outcome on a learned entry whose count equals its limit clears the confidence, and the count keeps incrementing.
- R9: The count is 8 bits. A usual outcome when the count is already 255 invalidates the entry, so the next lookup misses.
- R10: Lookup outputs are combinational from the lookup address. A resolve becomes visible to lookups right after the rising clock edge on which res_valid_i is sampled high.
- R11: Lookups never change table state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_ip_i | input | 32 | Branch address to look up |
| pred_hit_o | output | 1 | Lookup address has a valid entry |
| pred_conf_o | output | 1 | Entry is learned with saturated confidence |
| pred_dir_o | output | 1 | Predicted direction (1 = taken) |
| res_valid_i | input | 1 | A branch outcome is presented this cycle |
| res_ip_i | input | 32 | Address of the resolved branch |
| res_taken_i | input | 1 | Actual outcome (1 = taken) |

## Verification
Lookup results are due in the same cycle as the address. The bench therefore applies an address one time unit after a rising edge and reads the outputs one time unit later, well before the next edge. A resolve is driven on a falling edge and takes effect on the following rising edge, so any lookup that depends on it samples only after that edge. One check samples the same lookup just before and just after that edge to confirm the one-edge latency. Expected directions and confidence are derived arithmetically from the trip count and the round number: the exit occurrence is the one at index N, and confidence saturates from the fifth round on.

// File: rtl/loop_pred_pkg.sv
package loop_pred_pkg;

  typedef enum logic [1:0] {
    ACT_ALLOC,
    ACT_STEP,
    ACT_DROP,
    ACT_EXIT
  } upd_act_e;

  function automatic upd_act_e classify(input logic hit, input logic usual,
                                        input logic cnt_full);
    if (!hit)          return ACT_ALLOC;
    else if (!usual)   return ACT_EXIT;
    else if (cnt_full) return ACT_DROP;
    else               return ACT_STEP;
  endfunction

endpackage

// File: rtl/loop_pred_hash.sv
module loop_pred_hash #(
  parameter int unsigned HI_W  = 28,
  parameter int unsigned TAG_W = 8
) (
  input  logic [HI_W-1:0]  hi_i,
  output logic [TAG_W-1:0] tag_o
);
  // fold every upper address bit into the tag
  always_comb begin
    tag_o = '0;
    for (int j = 0; j < HI_W; j++) begin
      tag_o[j % TAG_W] = tag_o[j % TAG_W] ^ hi_i[j];
    end
  end
endmodule

// File: rtl/loop_pred_entry.sv
module loop_pred_entry
  import loop_pred_pkg::*;
#(
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CONF_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic              upd_taken_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              learned_o,
  output logic              dir_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CONF_W-1:0] conf_o
);
  localparam logic [CNT_W-1:0]  CntMax  = {CNT_W{1'b1}};
  localparam logic [CONF_W-1:0] ConfMax = {CONF_W{1'b1}};

  logic              valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic              learned_q, learned_d;
  logic              dir_q, dir_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  limit_q, limit_d;
  logic [CONF_W-1:0] conf_q, conf_d;

  logic     hit, at_lim;
  upd_act_e act;

  assign hit    = valid_q && (tag_q == upd_tag_i);
  assign at_lim = learned_q && (cnt_q == limit_q);
  assign act    = classify(hit, upd_taken_i == dir_q, cnt_q == CntMax);

  always_comb begin
    valid_d   = valid_q;
    tag_d     = tag_q;
    learned_d = learned_q;
    dir_d     = dir_q;
    cnt_d     = cnt_q;
    limit_d   = limit_q;
    conf_d    = conf_q;
    if (upd_en_i) begin
      unique case (act)
        ACT_ALLOC: begin
          valid_d   = 1'b1;
          tag_d     = upd_tag_i;
          learned_d = 1'b0;
          dir_d     = upd_taken_i;
          cnt_d     = {{(CNT_W-1){1'b0}}, 1'b1};
          limit_d   = '0;
          conf_d    = '0;
        end
        ACT_STEP: begin
          cnt_d = cnt_q + 1'b1;
          if (at_lim) conf_d = '0;  // ran past the learned exit
        end
        ACT_DROP: begin
          valid_d = 1'b0;
        end
        ACT_EXIT: begin
          cnt_d = '0;
          if (at_lim) begin
            conf_d = (conf_q == ConfMax) ? conf_q : conf_q + 1'b1;
          end else begin
            learned_d = 1'b1;
            limit_d   = cnt_q;
            conf_d    = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      tag_q     <= '0;
      learned_q <= 1'b0;
      dir_q     <= 1'b0;
      cnt_q     <= '0;
      limit_q   <= '0;
      conf_q    <= '0;
    end else begin
      valid_q   <= valid_d;
      tag_q     <= tag_d;
      learned_q <= learned_d;
      dir_q     <= dir_d;
      cnt_q     <= cnt_d;
      limit_q   <= limit_d;
      conf_q    <= conf_d;
    end
  end

  assign valid_o   = valid_q;
  assign tag_o     = tag_q;
  assign learned_o = learned_q;
  assign dir_o     = dir_q;
  assign cnt_o     = cnt_q;
  assign limit_o   = limit_q;
  assign conf_o    = conf_q;
endmodule

// File: rtl/loop_pred_lookup.sv
module loop_pred_lookup #(
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned CONF_W = 2
) (
  input  logic              valid_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              learned_i,
  input  logic              dir_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic [CONF_W-1:0] conf_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              hit_o,
  output logic              conf_o,
  output logic              dir_o
);
  logic exit_now;

  assign hit_o    = valid_i && (tag_i == req_tag_i);
  assign exit_now = learned_i && (cnt_i == limit_i);
  assign conf_o   = hit_o && learned_i && (conf_i == {CONF_W{1'b1}});
  assign dir_o    = exit_now ? ~dir_i : dir_i;
endmodule

// File: rtl/loop_pred.sv
module loop_pred #(
  parameter int unsigned IP_W    = 32,
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned CONF_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IP_W-1:0] pred_ip_i,
  output logic            pred_hit_o,
  output logic            pred_conf_o,
  output logic            pred_dir_o,
  input  logic            res_valid_i,
  input  logic [IP_W-1:0] res_ip_i,
  input  logic            res_taken_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned HI_W  = IP_W - IDX_W;

  logic [IDX_W-1:0] pred_idx, res_idx;
  logic [TAG_W-1:0] pred_tag, res_tag;

  assign pred_idx = pred_ip_i[IDX_W-1:0];
  assign res_idx  = res_ip_i[IDX_W-1:0];

  loop_pred_hash #(.HI_W(HI_W), .TAG_W(TAG_W)) u_pred_hash (
    .hi_i (pred_ip_i[IP_W-1:IDX_W]),
    .tag_o(pred_tag)
  );

  loop_pred_hash #(.HI_W(HI_W), .TAG_W(TAG_W)) u_res_hash (
    .hi_i (res_ip_i[IP_W-1:IDX_W]),
    .tag_o(res_tag)
  );

  logic              e_valid   [ENTRIES];
  logic [TAG_W-1:0]  e_tag     [ENTRIES];
  logic              e_learned [ENTRIES];
  logic              e_dir     [ENTRIES];
  logic [CNT_W-1:0]  e_cnt     [ENTRIES];
  logic [CNT_W-1:0]  e_limit   [ENTRIES];
  logic [CONF_W-1:0] e_conf    [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    loop_pred_entry #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CONF_W(CONF_W)) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_en_i   (res_valid_i && (res_idx == IDX_W'(g))),
      .upd_tag_i  (res_tag),
      .upd_taken_i(res_taken_i),
      .valid_o    (e_valid[g]),
      .tag_o      (e_tag[g]),
      .learned_o  (e_learned[g]),
      .dir_o      (e_dir[g]),
      .cnt_o      (e_cnt[g]),
      .limit_o    (e_limit[g]),
      .conf_o     (e_conf[g])
    );
  end

  loop_pred_lookup #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CONF_W(CONF_W)) u_lookup (
    .valid_i  (e_valid[pred_idx]),
    .tag_i    (e_tag[pred_idx]),
    .learned_i(e_learned[pred_idx]),
    .dir_i    (e_dir[pred_idx]),
    .cnt_i    (e_cnt[pred_idx]),
    .limit_i  (e_limit[pred_idx]),
    .conf_i   (e_conf[pred_idx]),
    .req_tag_i(pred_tag),
    .hit_o    (pred_hit_o),
    .conf_o   (pred_conf_o),
    .dir_o    (pred_dir_o)
  );

  // resolve-side hit, observed by the bound checker
  logic res_hit;
  assign res_hit = e_valid[res_idx] && (e_tag[res_idx] == res_tag);
endmodule

// File: rtl/loop_pred_chk.sv
module loop_pred_chk #(
  parameter int unsigned IP_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [IP_W-1:0] pred_ip_i,
  input logic            pred_hit_o,
  input logic            pred_conf_o,
  input logic            pred_dir_o,
  input logic            res_valid_i,
  input logic [IP_W-1:0] res_ip_i,
  input logic            res_taken_i,
  input logic            res_hit
);
  // R6
  conf_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_conf_o |-> pred_hit_o);

  // R2
  alloc_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !res_hit) |=>
      ((pred_ip_i != $past(res_ip_i)) ||
       (pred_hit_o && !pred_conf_o && (pred_dir_o == $past(res_taken_i)))));

  // R11
  lookup_readonly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(res_valid_i) && $stable(pred_ip_i)) |->
      $stable({pred_hit_o, pred_conf_o, pred_dir_o}));

  // R8
  mispredict_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && res_hit && (pred_ip_i == res_ip_i) && pred_conf_o &&
     (res_taken_i != pred_dir_o)) |=>
      ((pred_ip_i != $past(pred_ip_i)) || !pred_conf_o));
endmodule

bind loop_pred loop_pred_chk #(.IP_W(IP_W)) u_loop_pred_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pred_ip_i  (pred_ip_i),
  .pred_hit_o (pred_hit_o),
  .pred_conf_o(pred_conf_o),
  .pred_dir_o (pred_dir_o),
  .res_valid_i(res_valid_i),
  .res_ip_i   (res_ip_i),
  .res_taken_i(res_taken_i),
  .res_hit    (res_hit)
);

// File: tb/loop_pred_test.sv
`timescale 1ns/1ps
module loop_pred_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_ip_i = '0;
  logic        pred_hit_o, pred_conf_o, pred_dir_o;
  logic        res_valid_i = 1'b0;
  logic [31:0] res_ip_i = '0;
  logic        res_taken_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  loop_pred uut (
    .clk_i, .rst_ni, .pred_ip_i, .pred_hit_o, .pred_conf_o, .pred_dir_o,
    .res_valid_i, .res_ip_i, .res_taken_i
  );

  function automatic logic [31:0] mk_ip(input logic [7:0] tg, input logic [3:0] ix);
    return {20'h0, tg, ix};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_pred(input logic [31:0] ip, input logic eh, input logic ec,
                             input logic ed, input string req);
    pred_ip_i = ip;
    #1;
    chk(pred_hit_o == eh, {req, " hit"}, int'(pred_hit_o), int'(eh));
    if (eh) begin
      chk(pred_conf_o == ec, {req, " conf"}, int'(pred_conf_o), int'(ec));
      chk(pred_dir_o == ed, {req, " dir"}, int'(pred_dir_o), int'(ed));
    end else begin
      chk(pred_conf_o == 1'b0, {req, " conf"}, int'(pred_conf_o), 0);
    end
  endtask

  task automatic resolve(input logic [31:0] ip, input logic taken);
    @(negedge clk_i);
    res_ip_i    = ip;
    res_taken_i = taken;
    res_valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    res_valid_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] ip;
    logic        usual, ed;
    repeat (4) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1: empty after reset
    for (int ix = 0; ix < 16; ix++) expect_pred(mk_ip(8'h30 + 8'(ix), 4'(ix)), 0, 0, 0, "R1");

    // R10: update visible right after the sampling edge
    ip = mk_ip(8'h5A, 4'd13);
    pred_ip_i = ip;
    @(negedge clk_i);
    res_ip_i = ip; res_taken_i = 1'b1; res_valid_i = 1'b1;
    #1 chk(pred_hit_o == 1'b0, "R10 before edge", int'(pred_hit_o), 0);
    @(posedge clk_i);
    #1 res_valid_i = 1'b0;
    chk(pred_hit_o == 1'b1, "R10 after edge", int'(pred_hit_o), 1);

    // R2 R4 R5 R6: trip-count sweep
    for (int n = 1; n <= 10; n++) begin
      ip = mk_ip(8'h30 + 8'(n), 4'(n));
      usual = n[0];
      expect_pred(ip, 0, 0, 0, "R2 pre-alloc");
      resolve(ip, usual);
      expect_pred(ip, 1, 0, usual, "R2 alloc");
      for (int i = 1; i < n; i++) resolve(ip, usual);
      expect_pred(ip, 1, 0, usual, "R4 unlearned");
      resolve(ip, ~usual);
      for (int r = 2; r <= 6; r++) begin
        for (int i = 0; i <= n; i++) begin
          ed = (i == n) ? ~usual : usual;
          expect_pred(ip, 1, r >= 5, ed, (i == n) ? "R5 R6 exit" : "R5 R6 body");
          resolve(ip, ed);
        end
      end
    end

    // R8: run past limit 3, then exit at 5
    ip = mk_ip(8'h33, 4'd3);
    for (int i = 0; i < 3; i++) begin
      expect_pred(ip, 1, 1, 1, "R6 confident");
      resolve(ip, 1);
    end
    expect_pred(ip, 1, 1, 0, "R5 exit predicted");
    resolve(ip, 1);
    expect_pred(ip, 1, 0, 1, "R8 conf cleared");
    resolve(ip, 1);
    resolve(ip, 0);
    for (int i = 0; i <= 5; i++) begin
      ed = (i == 5) ? 1'b0 : 1'b1;
      expect_pred(ip, 1, 0, ed, "R7 longer limit");
      resolve(ip, ed);
    end

    // R7: early exit at 2 on limit 6
    ip = mk_ip(8'h36, 4'd6);
    for (int i = 0; i < 2; i++) begin
      expect_pred(ip, 1, 1, 0, "R6 confident");
      resolve(ip, 0);
    end
    resolve(ip, 1);
    expect_pred(ip, 1, 0, 0, "R7 conf cleared");
    for (int i = 0; i <= 2; i++) begin
      ed = (i == 2) ? 1'b1 : 1'b0;
      expect_pred(ip, 1, 0, ed, "R7 shorter limit");
      resolve(ip, ed);
    end

    // R3: tag fold, alias and replacement
    expect_pred(mk_ip(8'h31, 4'd1), 1, 1, 1, "R3 original");
    expect_pred(32'h0000_1000 | mk_ip(8'h30, 4'd1), 1, 1, 1, "R3 fold alias");
    ip = mk_ip(8'hA5, 4'd1);
    expect_pred(ip, 0, 0, 0, "R3 tag mismatch");
    resolve(ip, 0);
    expect_pred(ip, 1, 0, 0, "R3 replaced");
    expect_pred(mk_ip(8'h31, 4'd1), 0, 0, 0, "R3 evicted");

    // R9: count saturation invalidates
    ip = mk_ip(8'h77, 4'd12);
    repeat (255) resolve(ip, 1);
    expect_pred(ip, 1, 0, 1, "R9 count 255");
    resolve(ip, 1);
    expect_pred(ip, 0, 0, 0, "R9 overflow");

    // R11: lookups leave state untouched
    for (int k = 0; k < 8; k++) begin
      pred_ip_i = mk_ip(8'(k * 37), 4'(k));
      @(posedge clk_i);
      #1;
    end
    ip = mk_ip(8'h32, 4'd2);
    for (int i = 0; i <= 2; i++) begin
      ed = (i == 2) ? 1'b1 : 1'b0;
      expect_pred(ip, 1, 1, ed, "R11 state kept");
      resolve(ip, ed);
    end

    // R1: reset again mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    expect_pred(ip, 0, 0, 0, "R1 after re-reset");
    expect_pred(mk_ip(8'h35, 4'd5), 0, 0, 0, "R1 after re-reset");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule